// File: doc/BRIEF.md
# Single-Button Door Motor Controller

This block drives the motor of an overhead door from one push button and one end-of-travel sensor. The sensor is high whenever the door rests fully at the top or fully at the bottom. A press while the door is parked at either end sends it toward the other end. A press while it is moving halts it in place. The next press after such a halt sends it back the way it came, so the controller keeps track of which direction was interrupted.

The controller is a Moore machine with six states held in a 3-bit register. The motor command is decoded from the state alone. The raw button level passes through a rising-edge detector, so a button held for many cycles counts as a single press. Debouncing and obstruction sensing belong to other blocks.

Top module: `door_ctrl`

## Requirements
- R1: While `rst` is high and in the cycles after it, the door is taken as fully closed and the motor is off ({`mot_up`,`mot_down`} = 00).
- R2: The motor command is 00 for halted, 10 for raising and 01 for lowering. The value 11 never appears on the outputs.
- R3: When the door is parked closed, a press starts raising (10). When it is parked open, a press starts lowering (01).
- R4: While the door is moving and `at_end` is high, the motor stops (00) and the door is parked at the end it was heading to. A later press from there moves it the other way.
- R5: A press while the door is moving and `at_end` is low stops the motor (00) in place.
- R6: A press after a halt in place moves the door opposite to the interrupted travel: 01 after a halted rise, 10 after a halted descent.
- R7: Only a 0-to-1 change of `btn_raw` counts as a press. Holding the button high causes no further transitions. A button that is high during reset and stays high after it causes no press.
- R8: When a press and `at_end` arrive in the same cycle while the door is moving, `at_end` wins and the door parks at the end of its travel.
- R9: `at_end` has no effect while the door is parked or halted in place. The motor stays at 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Level of the push button, already debounced |
| at_end | input | 1 | High when the door rests at the top or at the bottom |
| mot_up | output | 1 | Motor raise command |
| mot_down | output | 1 | Motor lower command |

## Verification
The hardest corners are a press that lands in the same cycle as the end-of-travel sensor, and a press right after a halt in place. A design that let the press win would leave the door halted at an end with the wrong direction stored. A design that lost the interrupted direction would send the door onward instead of back. A held button, or one held across reset, must produce exactly one transition or none at all. A level-sensitive button path would make the door cycle through its states instead. A long pseudo-random stream of press and sensor patterns is compared cycle by cycle against a model built from the requirements. That stream also shows whether a stray sensor pulse moves a parked or halted door.

// File: rtl/door_pkg.sv
package door_pkg;

    localparam int unsigned ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_SHUT     = 3'd0,
        ST_RISE     = 3'd1,
        ST_HALT_UP  = 3'd2,
        ST_FULL     = 3'd3,
        ST_FALL     = 3'd4,
        ST_HALT_DN  = 3'd5
    } door_st_e;

    typedef struct packed {
        logic up;
        logic down;
    } motor_t;

    function automatic logic is_moving(door_st_e s);
        return (s == ST_RISE) || (s == ST_FALL);
    endfunction

    function automatic logic is_still(door_st_e s);
        return (s == ST_SHUT) || (s == ST_FULL) ||
               (s == ST_HALT_UP) || (s == ST_HALT_DN);
    endfunction

    function automatic motor_t motor_for(door_st_e s);
        motor_t m;
        m.up   = (s == ST_RISE);
        m.down = (s == ST_FALL);
        return m;
    endfunction

endpackage

// File: rtl/door_click_edge.sv
module door_click_edge (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic click
);
    logic btn_q;

    // Reset loads 1 so that a button held through reset gives no press (R7).
    always_ff @(posedge clk) begin
        if (rst) btn_q <= 1'b1;
        else     btn_q <= btn_raw;
    end

    assign click = btn_raw & ~btn_q;

    // R7: a held button yields at most one press.
    a_r7_single_press: assert property (@(posedge clk) disable iff (rst)
        (click && btn_raw) |=> !click);

endmodule

// File: rtl/door_seq.sv
module door_seq
    import door_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     click,
    input  logic     at_end,
    output door_st_e state
);
    door_st_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_SHUT:    if (click) nxt = ST_RISE;
            ST_FULL:    if (click) nxt = ST_FALL;
            ST_RISE: begin
                if (at_end)     nxt = ST_FULL;      // sensor outranks press
                else if (click) nxt = ST_HALT_UP;
            end
            ST_FALL: begin
                if (at_end)     nxt = ST_SHUT;
                else if (click) nxt = ST_HALT_DN;
            end
            ST_HALT_UP: if (click) nxt = ST_FALL;
            ST_HALT_DN: if (click) nxt = ST_RISE;
            default:    nxt = ST_SHUT;              // unused codes recover
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SHUT;
        else     state <= nxt;
    end

    a_r1_reset_closed: assert property (@(posedge clk)
        rst |=> (state == ST_SHUT));

    a_r8_end_wins: assert property (@(posedge clk) disable iff (rst)
        (is_moving(state) && at_end) |=> (state == ST_SHUT || state == ST_FULL));

    a_r5_press_halts: assert property (@(posedge clk) disable iff (rst)
        (is_moving(state) && click && !at_end) |=>
            (state == ST_HALT_UP || state == ST_HALT_DN));

    a_r6_reverse: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT_UP && click) |=> (state == ST_FALL));

    a_r9_still_holds: assert property (@(posedge clk) disable iff (rst)
        (is_still(state) && !click) |=> $stable(state));

endmodule

// File: rtl/door_motor_drive.sv
module door_motor_drive
    import door_pkg::*;
(
    input  door_st_e state,
    output logic     mot_up,
    output logic     mot_down
);
    motor_t m;

    always_comb begin
        m        = motor_for(state);
        mot_up   = m.up;
        mot_down = m.down;
        // R2: both commands high is forbidden.
        a_r2_motor_exclusive: assert (!(mot_up && mot_down));
    end

endmodule

// File: rtl/door_ctrl.sv
module door_ctrl
    import door_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    input  logic at_end,
    output logic mot_up,
    output logic mot_down
);
    logic     click;
    door_st_e state;

    door_click_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (btn_raw),
        .click   (click)
    );

    door_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .click  (click),
        .at_end (at_end),
        .state  (state)
    );

    door_motor_drive u_drive (
        .state    (state),
        .mot_up   (mot_up),
        .mot_down (mot_down)
    );

endmodule

// File: tb/door_ctrl_tb.sv
`timescale 1ns/1ps
module door_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_raw = 1'b0;
    logic at_end = 1'b0;
    logic mot_up, mot_down;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model: 0 shut, 1 rise, 2 halted rising, 3 full, 4 fall, 5 halted falling
    int  m_st = 0;
    bit  m_prev = 1'b1;

    always #2.5 clk = ~clk;

    door_ctrl u_dut (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .at_end(at_end),
        .mot_up(mot_up), .mot_down(mot_down)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: motor got %b expected %b (t=%0t)", req, got, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_motor(int s);
        if (s == 1) return 2'b10;
        if (s == 4) return 2'b01;
        return 2'b00;
    endfunction

    // Drive at a falling edge, advance the model, check at the next falling edge.
    task automatic step(input bit b, input bit c);
        bit press;
        string tag;
        int nx;
        btn_raw = b;
        at_end  = c;
        press   = b && !m_prev;
        m_prev  = b;
        nx  = m_st;
        tag = "R2";
        if (m_st == 1 || m_st == 4) begin
            if (c) begin
                nx  = (m_st == 1) ? 3 : 0;
                tag = press ? "R8" : "R4";
            end else if (press) begin
                nx  = (m_st == 1) ? 2 : 5;
                tag = "R5";
            end else if (b) tag = "R7";
        end else if (press) begin
            case (m_st)
                0: begin nx = 1; tag = "R3"; end
                3: begin nx = 4; tag = "R3"; end
                2: begin nx = 4; tag = "R6"; end
                default: begin nx = 1; tag = "R6"; end
            endcase
        end else if (b) tag = "R7";
        else if (c) tag = "R9";
        m_st = nx;
        @(negedge clk);
        check(tag, {mot_up, mot_down}, exp_motor(m_st));
        if (mot_up && mot_down) begin
            n_bad++;
            $display("FAIL R2: motor got 11 expected not 11");
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // Button held high during reset must not count as a press (R7).
        btn_raw = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", {mot_up, mot_down}, 2'b00);
        rst = 1'b0;
        m_st = 0; m_prev = 1'b1;
        step(1, 0);                       // R7: still held after reset
        check("R7", {mot_up, mot_down}, 2'b00);
        step(0, 0);
        check("R1", {mot_up, mot_down}, 2'b00);
        step(0, 1);                       // R9: sensor while closed
        check("R9", {mot_up, mot_down}, 2'b00);
        step(1, 0);                       // R3 press from closed
        check("R3", {mot_up, mot_down}, 2'b10);
        step(1, 0); step(1, 0);           // R7 held
        check("R7", {mot_up, mot_down}, 2'b10);
        step(0, 0);
        step(1, 0);                       // R5 halt mid-rise
        check("R5", {mot_up, mot_down}, 2'b00);
        step(0, 1);                       // R9 sensor while halted
        step(0, 0);
        step(1, 0);                       // R6 reverse: lower
        check("R6", {mot_up, mot_down}, 2'b01);
        step(0, 0);
        step(1, 1);                       // R8 press and end together
        check("R8", {mot_up, mot_down}, 2'b00);
        step(0, 0);
        step(1, 0);                       // R4: parked closed, next press raises
        check("R4", {mot_up, mot_down}, 2'b10);
        step(0, 1);                       // R4 reach top
        check("R4", {mot_up, mot_down}, 2'b00);
        step(1, 0);                       // R3 from open: lower
        check("R3", {mot_up, mot_down}, 2'b01);
        step(0, 0);
        step(1, 0);                       // R5 halt mid-descent
        step(0, 0);
        step(1, 0);                       // R6 reverse: raise
        check("R6", {mot_up, mot_down}, 2'b10);

        // Pseudo-random sweep over press and sensor patterns.
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7] & lfsr[2], (lfsr[11:9] == 3'b000));
        end

        // Reset in mid-travel returns to closed (R1).
        step(0, 0); step(1, 0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", {mot_up, mot_down}, 2'b00);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule